// File: doc/BRIEF.md
# Bus Master Security Filter

This block sits on the path from one bus master to a memory-mapped downstream port. Every request presented by the master is classified using an external attribution lookup. The lookup is a combinational port: the block drives the request address out and gets back two flags, "exempt from checking" and "non-secure region". From these flags and the master's configured security state, the block picks one of four outcomes. The access is forwarded as secure, forwarded as non-secure, completed locally as read-as-zero/write-ignored, or completed locally with an error.

Three sideband levels configure the filter:

- master-is-non-secure;
- blocked-response select, which chooses silent completion or an error;
- interrupt clear.

All three are registered on entry. A blocked access that ends in an error sets a sticky status bit, and that bit drives the level interrupt output.

The upstream request carries a right-justified value and a size code. The downstream side is a lane-aligned 64-bit little-endian bus with byte strobes. The filter places write bytes onto the lanes and extracts read bytes from them. At most one forwarded access is outstanding at a time.

Top module: `bus_sec_filter`

## Requirements
- R1: When the lookup reports the address exempt, the access is forwarded, with the downstream secure flag high exactly when the registered master-is-non-secure level is low.
- R2: When the address is not exempt and the lookup reports a non-secure region, the access is forwarded with the secure flag low, whatever the master configuration.
- R3: For a secure-region address with master-is-non-secure low, the access is forwarded with the secure flag high.
- R4: For a secure-region address with master-is-non-secure high and the response select low, no downstream request is issued. The request is accepted in the cycle it is presented, and the next cycle carries an upstream response with error low and read data zero. Write data is discarded.
- R5: In the same blocked case with the response select high, no downstream request is issued, and the next cycle carries an upstream response with error high.
- R6: An error-type block sets the interrupt output from the following cycle. It then stays high until a clear is applied.
- R7: While the registered interrupt-clear level is high, the interrupt output is low. An error-type block during that time does not set it.
- R8: While reset is low, the interrupt output, the upstream response valid and the downstream request valid are all low. The registered sideband copies reset to zero, so an access in the first cycle after reset sees a secure master. A sideband change takes effect one cycle after it is driven.
- R9: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes, and addresses are aligned to the size. On a forwarded access, upstream write byte k goes to downstream lane addr[2:0]+k, with a strobe bit set for exactly those lanes.
- R10: Read data returns downstream lane addr[2:0]+k in upstream byte k (bits 8k+7:8k), with the bytes above the access size zero. The downstream error bit is passed back unchanged.
- R11: On a forwarded access, upstream ready follows downstream ready, and address, write flag and size are passed unchanged. The upstream response is valid in the same cycle as the downstream response, and no new request is taken while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master_ns | input | 1 | Master is configured non-secure |
| cfg_blk_err | input | 1 | Blocked accesses answer with an error (1) or silently (0) |
| irq_clr | input | 1 | Interrupt clear level |
| irq | output | 1 | Level interrupt, equals the status bit |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request accepted |
| up_req_addr | input | ADDR_W | Access address |
| up_req_write | input | 1 | 1 for write, 0 for read |
| up_req_size | input | 2 | Size code, bytes = 1 << code |
| up_req_wdata | input | DATA_W | Right-justified write value |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_rdata | output | DATA_W | Right-justified read value |
| up_rsp_err | output | 1 | Error response |
| attr_addr | output | ADDR_W | Address sent to the attribution lookup |
| attr_exempt | input | 1 | Lookup: address exempt from checking |
| attr_nonsec | input | 1 | Lookup: address in a non-secure region |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_addr | output | ADDR_W | Downstream address |
| dn_req_write | output | 1 | Downstream write flag |
| dn_req_size | output | 2 | Downstream size code |
| dn_req_secure | output | 1 | Security attribute of the forwarded access |
| dn_req_wdata | output | DATA_W | Lane-aligned write data |
| dn_req_strb | output | DATA_W/8 | Byte lane strobes |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_rdata | input | DATA_W | Lane-aligned read data |
| dn_rsp_err | input | 1 | Downstream error |

## Verification
The assertions rely on a few properties of the environment:

- every presented address is aligned to its size;
- the downstream side answers only while a forwarded access is outstanding;
- the lookup flags follow the current request address within the same cycle.

The bench keeps to all three. Its addresses are masked to the size before use, and its downstream responder only drives a response after it has observed the accepting handshake. Its attribution model is a pure function of the address bits. Sideband changes are made between accesses and followed by two idle cycles, so each access sees a settled configuration.

// File: rtl/bsf_pkg.sv
// Shared types of the bus security filter.
// Assumes: nothing beyond being compiled first.
package bsf_pkg;

    // Per-access outcome chosen by the decision logic.
    typedef enum logic [1:0] {
        ACT_FWD_SEC  = 2'd0,
        ACT_FWD_NS   = 2'd1,
        ACT_BLK_ZERO = 2'd2,
        ACT_BLK_ERR  = 2'd3
    } bsf_act_e;

    // Transaction sequencing state of the filter.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_BLK  = 2'd2
    } bsf_state_e;

    localparam int SIZE_W = 2;

endpackage

// File: rtl/bsf_decide.sv
// Four-way access decision from the lookup flags and the registered
// sideband configuration. Purely combinational.
// Assumes: flags belong to the address currently presented.
module bsf_decide
    import bsf_pkg::*;
(
    input  logic     exempt_i,
    input  logic     nonsec_i,
    input  logic     master_ns_i,
    input  logic     blk_err_i,
    output bsf_act_e act_o
);

    // Priority: exempt, then non-secure region, then master state.
    always_comb begin
        if (exempt_i)
            act_o = master_ns_i ? ACT_FWD_NS : ACT_FWD_SEC;
        else if (nonsec_i)
            act_o = ACT_FWD_NS;
        else if (!master_ns_i)
            act_o = ACT_FWD_SEC;
        else if (blk_err_i)
            act_o = ACT_BLK_ERR;
        else
            act_o = ACT_BLK_ZERO;
    end

endmodule

// File: rtl/bsf_lanes.sv
// Little-endian byte lane steering between a right-justified upstream
// value and a lane-aligned downstream bus.
// Assumes: DATA_W is 64 so size codes 0..3 are all legal, and the
// offset is aligned to the size.
module bsf_lanes
    import bsf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [$clog2(DATA_W/8)-1:0] ofs_i,
    input  logic [SIZE_W-1:0]           size_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic [DATA_W-1:0]           lane_rdata_i,
    output logic [DATA_W-1:0]           lane_wdata_o,
    output logic [DATA_W/8-1:0]         strb_o,
    output logic [DATA_W-1:0]           rdata_o
);

    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    logic [OFS_W:0]    nbytes;
    logic [OFS_W:0]    ofs_ext;
    logic [DATA_W-1:0] rshift;

    assign nbytes       = (OFS_W+1)'(1) << size_i;
    assign ofs_ext      = {1'b0, ofs_i};
    assign lane_wdata_o = wdata_i << {ofs_i, 3'b000};
    assign rshift       = lane_rdata_i >> {ofs_i, 3'b000};

    // Per lane: strobe window and read byte masking.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFS_W:0] IDX = (OFS_W+1)'(i);
        assign strb_o[i] = (ofs_ext <= IDX) && (IDX < (ofs_ext + nbytes));
        assign rdata_o[8*i +: 8] = (IDX < nbytes) ? rshift[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/bsf_irq.sv
// Sticky interrupt status: set by an error-type block, held cleared
// while the clear level is high (clear wins over set).
// Assumes: clr_i is already registered by the caller.
module bsf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    // Status bit update.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_o <= 1'b0;
        else if (clr_i)  irq_o <= 1'b0;
        else if (set_i)  irq_o <= 1'b1;
    end

    assert_clr_holds_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !irq_o);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> irq_o);

    assert_rise_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(set_i));

endmodule

// File: rtl/bus_sec_filter.sv
// Bus master security filter. Classifies each upstream access via an
// external attribution lookup and either forwards it downstream with a
// security attribute or completes it locally (zero/ignore or error).
// Assumes: aligned accesses, one outstanding forwarded access, and a
// downstream that answers only while an access is outstanding.
module bus_sec_filter
    import bsf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_master_ns,
    input  logic                cfg_blk_err,
    input  logic                irq_clr,
    output logic                irq,
    input  logic                up_req_valid,
    output logic                up_req_ready,
    input  logic [ADDR_W-1:0]   up_req_addr,
    input  logic                up_req_write,
    input  logic [SIZE_W-1:0]   up_req_size,
    input  logic [DATA_W-1:0]   up_req_wdata,
    output logic                up_rsp_valid,
    output logic [DATA_W-1:0]   up_rsp_rdata,
    output logic                up_rsp_err,
    output logic [ADDR_W-1:0]   attr_addr,
    input  logic                attr_exempt,
    input  logic                attr_nonsec,
    output logic                dn_req_valid,
    input  logic                dn_req_ready,
    output logic [ADDR_W-1:0]   dn_req_addr,
    output logic                dn_req_write,
    output logic [SIZE_W-1:0]   dn_req_size,
    output logic                dn_req_secure,
    output logic [DATA_W-1:0]   dn_req_wdata,
    output logic [DATA_W/8-1:0] dn_req_strb,
    input  logic                dn_rsp_valid,
    input  logic [DATA_W-1:0]   dn_rsp_rdata,
    input  logic                dn_rsp_err
);

    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    logic        ns_q, blkerr_q, clr_q;
    bsf_state_e  state_q;
    logic        rsp_err_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [SIZE_W-1:0] size_q;
    bsf_act_e    act;
    logic        fwd, idle, accept;
    logic [DATA_W-1:0] rd_extract;
    logic [DATA_W-1:0] unused_rd;
    logic [DATA_W-1:0] unused_wd;
    logic [LANES-1:0]  unused_strb;

    // Register the sideband levels; reset makes them zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns_q     <= 1'b0;
            blkerr_q <= 1'b0;
            clr_q    <= 1'b0;
        end else begin
            ns_q     <= cfg_master_ns;
            blkerr_q <= cfg_blk_err;
            clr_q    <= irq_clr;
        end
    end

    assign attr_addr = up_req_addr;

    bsf_decide u_decide (
        .exempt_i    (attr_exempt),
        .nonsec_i    (attr_nonsec),
        .master_ns_i (ns_q),
        .blk_err_i   (blkerr_q),
        .act_o       (act)
    );

    assign fwd    = (act == ACT_FWD_SEC) || (act == ACT_FWD_NS);
    assign idle   = (state_q == ST_IDLE);
    assign dn_req_valid = idle && up_req_valid && fwd;
    assign up_req_ready = idle && (fwd ? dn_req_ready : 1'b1);
    assign accept       = up_req_valid && up_req_ready;

    assign dn_req_addr   = up_req_addr;
    assign dn_req_write  = up_req_write;
    assign dn_req_size   = up_req_size;
    assign dn_req_secure = (act == ACT_FWD_SEC);

    // Write path steering for the current request.
    bsf_lanes #(.DATA_W(DATA_W)) u_wlanes (
        .ofs_i        (up_req_addr[OFS_W-1:0]),
        .size_i       (up_req_size),
        .wdata_i      (up_req_wdata),
        .lane_rdata_i ('0),
        .lane_wdata_o (dn_req_wdata),
        .strb_o       (dn_req_strb),
        .rdata_o      (unused_rd)
    );

    // Read path steering using the captured offset and size.
    bsf_lanes #(.DATA_W(DATA_W)) u_rlanes (
        .ofs_i        (ofs_q),
        .size_i       (size_q),
        .wdata_i      ('0),
        .lane_rdata_i (dn_rsp_rdata),
        .lane_wdata_o (unused_wd),
        .strb_o       (unused_strb),
        .rdata_o      (rd_extract)
    );

    // Sequencing: idle, waiting on downstream, or local blocked reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rsp_err_q <= 1'b0;
            ofs_q     <= '0;
            size_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    ofs_q     <= up_req_addr[OFS_W-1:0];
                    size_q    <= up_req_size;
                    rsp_err_q <= (act == ACT_BLK_ERR);
                    state_q   <= fwd ? ST_WAIT : ST_BLK;
                end
                ST_WAIT: if (dn_rsp_valid) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign up_rsp_valid = (state_q == ST_BLK) || ((state_q == ST_WAIT) && dn_rsp_valid);
    assign up_rsp_err   = (state_q == ST_BLK) ? rsp_err_q : dn_rsp_err;
    assign up_rsp_rdata = (state_q == ST_WAIT) ? rd_extract : '0;

    bsf_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (accept && (act == ACT_BLK_ERR)),
        .clr_i (clr_q),
        .irq_o (irq)
    );

    assert_block_no_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> (attr_exempt || attr_nonsec || !ns_q));

    assert_ns_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !attr_exempt && attr_nonsec) |-> !dn_req_secure);

    assert_local_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !dn_req_valid) |=> (up_rsp_valid && !dn_req_valid));

    assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && dn_req_ready) |=> !dn_req_valid);

    assert_rsp_only_when_waiting_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dn_rsp_valid |-> (state_q == ST_WAIT));

    assert_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        up_req_valid |-> ((up_req_addr[OFS_W-1:0] & ((OFS_W)'(1 << up_req_size) - 1'b1)) == '0));

endmodule

// File: tb/bus_sec_filter_bench.sv
// Self-checking bench: directed corner cases then seeded random accesses.
module bus_sec_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_master_ns, cfg_blk_err, irq_clr;
    logic        irq;
    logic        up_req_valid, up_req_ready;
    logic [31:0] up_req_addr;
    logic        up_req_write;
    logic [1:0]  up_req_size;
    logic [63:0] up_req_wdata;
    logic        up_rsp_valid;
    logic [63:0] up_rsp_rdata;
    logic        up_rsp_err;
    logic [31:0] attr_addr;
    logic        attr_exempt, attr_nonsec;
    logic        dn_req_valid, dn_req_ready;
    logic [31:0] dn_req_addr;
    logic        dn_req_write;
    logic [1:0]  dn_req_size;
    logic        dn_req_secure;
    logic [63:0] dn_req_wdata;
    logic [7:0]  dn_req_strb;
    logic        dn_rsp_valid;
    logic [63:0] dn_rsp_rdata;
    logic        dn_rsp_err;

    int checks = 0;
    int errors = 0;
    logic m_ns, m_be, m_clr, irq_exp;

    always #2 clk = ~clk;

    // Attribution model: top two bits 11 = exempt, bit 28 = non-secure.
    assign attr_exempt = (attr_addr[31:30] == 2'b11);
    assign attr_nonsec = attr_addr[28];

    bus_sec_filter u_bus_sec_filter (.*);

    function automatic logic [1:0] exp_act(input logic [31:0] a, input logic ns, input logic be);
        if (a[31:30] == 2'b11) return ns ? 2'd1 : 2'd0;
        if (a[28])             return 2'd1;
        if (!ns)               return 2'd0;
        return be ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [63:0] lane_pat(input logic [31:0] a);
        logic [63:0] p;
        for (int i = 0; i < 8; i++) p[8*i +: 8] = (a[7:0] + 8'(i * 29)) ^ 8'h5A;
        return p;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access starting at a negedge; ends at a negedge.
    task automatic xact(input logic [31:0] a, input logic w, input logic [1:0] sz,
                        input logic [63:0] wd, input logic force_rdy,
                        input logic rsp_err, input string tag_in);
        logic [1:0]  ea;
        logic        fwd, seen, accepted;
        logic        c_sec, c_wr;
        logic [31:0] c_addr;
        logic [1:0]  c_sz;
        logic [7:0]  c_strb, e_strb;
        logic [63:0] c_wd, e_wd, wmask, e_rd, pat;
        int          nb, ofs, lat;
        string       tag;
        ea  = exp_act(a, m_ns, m_be);
        fwd = (ea < 2'd2);
        if (tag_in != "")                 tag = tag_in;
        else if (ea == 2'd2)              tag = "R4";
        else if (ea == 2'd3)              tag = "R5";
        else if (a[31:30] == 2'b11)       tag = "R1";
        else if (a[28])                   tag = "R2";
        else                              tag = "R3";
        nb = 1 << sz; ofs = int'(a[2:0]);
        seen = 1'b0; accepted = 1'b0;
        c_sec = 1'b0; c_wr = 1'b0; c_addr = '0; c_sz = '0; c_strb = '0; c_wd = '0;
        up_req_valid = 1'b1; up_req_addr = a; up_req_write = w;
        up_req_size = sz; up_req_wdata = wd;
        while (!accepted) begin
            dn_req_ready = force_rdy ? 1'b1 : 1'($urandom_range(0, 1));
            #1;
            if (dn_req_valid) begin
                seen = 1'b1; c_sec = dn_req_secure; c_strb = dn_req_strb;
                c_wd = dn_req_wdata; c_addr = dn_req_addr; c_wr = dn_req_write; c_sz = dn_req_size;
            end
            accepted = up_req_ready;
            @(negedge clk);
        end
        up_req_valid = 1'b0; dn_req_ready = 1'b0;
        if (ea == 2'd3 && !m_clr) irq_exp = 1'b1;
        chk({tag, " forward"}, 64'(seen), 64'(fwd));
        e_strb = '0; e_wd = '0; wmask = '0; e_rd = '0; pat = lane_pat(a);
        for (int k = 0; k < nb; k++) begin
            e_strb[ofs + k] = 1'b1;
            e_wd[8*(ofs + k) +: 8] = wd[8*k +: 8];
            wmask[8*(ofs + k) +: 8] = 8'hFF;
            e_rd[8*k +: 8] = pat[8*(ofs + k) +: 8];
        end
        if (fwd) begin
            chk({tag, " secure attr"}, 64'(c_sec), 64'(ea == 2'd0));
            chk("R11 addr/write/size pass", {c_addr, 29'(0), c_wr, c_sz}, {a, 29'(0), w, sz});
            chk("R9 strobes", 64'(c_strb), 64'(e_strb));
            if (w) chk("R9 write lanes", c_wd & wmask, e_wd);
            lat = $urandom_range(0, 2);
            repeat (lat) begin
                #1 chk("R11 no early response", 64'(up_rsp_valid), 64'(0));
                @(negedge clk);
            end
            dn_rsp_valid = 1'b1; dn_rsp_rdata = pat; dn_rsp_err = rsp_err;
            #1;
            chk("R11 response same cycle", 64'(up_rsp_valid), 64'(1));
            chk("R10 error passthrough", 64'(up_rsp_err), 64'(rsp_err));
            if (!w) chk("R10 read extract", up_rsp_rdata, e_rd);
            chk("R6 irq level", 64'(irq), 64'(irq_exp));
            @(negedge clk);
            dn_rsp_valid = 1'b0;
        end else begin
            #1;
            chk({tag, " local response"}, 64'(up_rsp_valid), 64'(1));
            chk({tag, " error bit"}, 64'(up_rsp_err), 64'(ea == 2'd3));
            chk({tag, " read zero"}, up_rsp_rdata, 64'(0));
            chk(m_clr ? "R7 irq level" : "R6 irq level", 64'(irq), 64'(irq_exp));
            @(negedge clk);
        end
    endtask

    // Change sideband at a negedge and let it settle for two cycles.
    task automatic set_cfg(input logic ns, input logic be, input logic clr);
        cfg_master_ns = ns; cfg_blk_err = be; irq_clr = clr;
        repeat (2) @(negedge clk);
        m_ns = ns; m_be = be; m_clr = clr;
        if (clr) irq_exp = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [1:0]  sz;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_master_ns = 1'b1; cfg_blk_err = 1'b1; irq_clr = 1'b0;
        up_req_valid = 1'b0; up_req_addr = '0; up_req_write = 1'b0; up_req_size = '0;
        up_req_wdata = '0; dn_req_ready = 1'b0; dn_rsp_valid = 1'b0;
        dn_rsp_rdata = '0; dn_rsp_err = 1'b0;
        m_ns = 1'b0; m_be = 1'b0; m_clr = 1'b0; irq_exp = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R8 irq in reset", 64'(irq), 64'(0));
        chk("R8 rsp valid in reset", 64'(up_rsp_valid), 64'(0));
        chk("R8 dn valid in reset", 64'(dn_req_valid), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        // First cycle after reset: registered master state is still zero.
        xact(32'h0000_1000, 1'b0, 2'd2, '0, 1'b1, 1'b0, "R8");
        m_ns = 1'b1; m_be = 1'b1;

        set_cfg(1'b0, 1'b0, 1'b0);
        xact(32'hC000_0010, 1'b0, 2'd0, '0, 1'b0, 1'b0, "");
        xact(32'h0000_2000, 1'b1, 2'd3, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, "");
        xact(32'h1000_0004, 1'b0, 2'd2, '0, 1'b0, 1'b1, "");
        set_cfg(1'b1, 1'b0, 1'b0);
        xact(32'hC000_0007, 1'b1, 2'd0, 64'hA5, 1'b0, 1'b0, "");
        xact(32'h1000_0006, 1'b0, 2'd1, '0, 1'b0, 1'b0, "");
        xact(32'h0000_3000, 1'b0, 2'd3, '0, 1'b0, 1'b0, "");
        xact(32'h0000_3008, 1'b1, 2'd2, 64'hDEAD_BEEF, 1'b0, 1'b0, "");
        set_cfg(1'b1, 1'b1, 1'b0);
        xact(32'h0000_4000, 1'b0, 2'd2, '0, 1'b0, 1'b0, "");
        xact(32'h1000_0000, 1'b0, 2'd3, '0, 1'b0, 1'b0, "R6");
        set_cfg(1'b1, 1'b1, 1'b1);
        #1 chk("R7 clear drops irq", 64'(irq), 64'(0));
        @(negedge clk);
        xact(32'h0000_5000, 1'b1, 2'd2, 64'h55, 1'b0, 1'b0, "R7");
        set_cfg(1'b1, 1'b1, 1'b0);
        #1 chk("R7 irq stays low after clear", 64'(irq), 64'(0));
        @(negedge clk);
        xact(32'h0000_5004, 1'b0, 2'd2, '0, 1'b0, 1'b0, "");

        for (int n = 0; n < 200; n++) begin
            if (n % 16 == 0)
                set_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                        1'($urandom_range(0, 7) == 0));
            sz = 2'($urandom_range(0, 3));
            a = $urandom();
            a[29] = 1'b0;
            a = a & ~((32'd1 << sz) - 32'd1);
            xact(a, 1'($urandom_range(0, 1)), sz, {$urandom(), $urandom()}, 1'b0,
                 1'($urandom_range(0, 3) == 0), "");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule